// File: doc/BRIEF.md
# 3x3 Streaming Convolution Engine with Bypass

The engine filters a raster stream of 8-bit pixels with a 3x3 kernel of signed coefficients. Two line buffers hold the two lines above the current input line. Together with a small column shift window they form a full 3x3 neighbourhood for every accepted pixel. Nine products are summed at full width. The sum is shifted right arithmetically by a programmable amount and clamped to 0..255. Software loads the nine coefficients and the shift amount through a small write port while the engine is disabled, and then enables it. Enable changes only between frames, once the output stage has drained.

When enabled, each accepted input pixel produces exactly one output pixel one cycle later. The output at line y carries the neighbourhood spanning input lines y-2..y, so filtered content trails the input by two lines. When disabled, the stream passes straight from input to output with no register on the path. Both streams use valid/ready. A transfer happens on a clock edge where valid and ready are both high. A source keeps its valid, data and markers steady until the transfer. When enabled, the input is ready whenever the output register is empty or the sink is ready, so a stalled sink holds the whole pipe. When disabled, the input ready follows the sink ready.

Top module: `conv3x3_stream`

## Requirements
- R1: After reset, the output valid is low, the input ready is high while the sink is ready, and all coefficients and the shift amount are zero.
- R2: A write with cw_en high while en is low stores cw_data as a signed coefficient for cw_idx 0..8, or its low 5 bits as the shift amount for cw_idx 9. Tap index 3*r+c multiplies the pixel in row r (0 = two lines above the current line) and column c (0 = two pixels left of the current pixel).
- R3: Coefficient and shift writes made while en is high have no effect on later results.
- R4: When enabled, the output for input position (line y, column x), with y>=2 and x>=2, is the sum over r,c of tap[3r+c]*pixel[y-2+r][x-2+c]. This sum is shifted right arithmetically by the shift amount and clamped to 0..255.
- R5: When enabled, outputs for positions with y<2 or x<2 are zero.
- R6: When enabled, each accepted input produces one output in order on the next cycle. The output carries the same start-of-frame (s_sof) and start-of-line (s_sol) markers as that input.
- R7: A start-of-frame marker restarts the line count, so the first two lines of every frame are zero and no pixel of an earlier frame reaches a result.
- R8: When disabled, with the output register empty, m_valid, m_data, m_sof and m_sol equal the input signals in the same cycle, and s_ready equals m_ready.
- R9: While m_valid is high and m_ready is low in enabled mode, the output stays valid and its data and markers stay unchanged.
- R10: A start-of-line marker restarts the column count, so lines shorter than the line-buffer length are filtered correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Engine enable; low selects pass-through |
| cw_en | input | 1 | Coefficient write strobe |
| cw_idx | input | 4 | Write index: 0..8 taps, 9 shift |
| cw_data | input | 8 | Write value |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high with s_valid |
| s_data | input | 8 | Input pixel |
| s_sof | input | 1 | Input pixel is first of a frame |
| s_sol | input | 1 | Input pixel is first of a line |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Sink ready |
| m_data | output | 8 | Output pixel |
| m_sof | output | 1 | Output start-of-frame marker |
| m_sol | output | 1 | Output start-of-line marker |

## Verification
Random images under a smoothing kernel with a nonzero shift separate correct tap placement and rounding from transposed or mirrored windows. A constant-white frame with all-ones taps drives the upper clamp, and a kernel with a strong negative centre drives the lower clamp. A ramp frame sent after an enabled-mode write shows whether that write leaked in. Back-to-back frames with very different content, a one-line frame, and short lines expose stale line-buffer data and counters that fail to restart. A pass-through frame under random sink stalls checks zero-delay forwarding and ready propagation.

// File: rtl/conv3_pkg.sv
package conv3_pkg;
  localparam int NTAP = 9;
  localparam int KDIM = 3;
endpackage

// File: rtl/conv3_coef_regs.sv
module conv3_coef_regs
  import conv3_pkg::*;
#(
  parameter int COEF_W = 8,
  parameter int SH_W   = 5,
  parameter int IDX_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [COEF_W-1:0]        wr_data,
  output logic [NTAP*COEF_W-1:0]   coef_flat,
  output logic [SH_W-1:0]          shift
);
  logic wr_ok;
  assign wr_ok = wr_en && !en;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    logic [COEF_W-1:0] tap_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                        tap_q <= '0;
      else if (wr_ok && wr_idx == IDX_W'(i))             tap_q <= wr_data;
    end
    assign coef_flat[i*COEF_W +: COEF_W] = tap_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                          shift <= '0;
    else if (wr_ok && wr_idx == IDX_W'(NTAP))            shift <= wr_data[SH_W-1:0];
  end

  // R3: an enabled cycle never changes the kernel
  a_r3_kernel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> ($stable(coef_flat) && $stable(shift)));
endmodule

// File: rtl/conv3_window.sv
module conv3_window
  import conv3_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int LINE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic [PIX_W-1:0]        pix,
  input  logic                    sof,
  input  logic                    sol,
  output logic [NTAP*PIX_W-1:0]   win_flat,
  output logic                    border
);
  localparam int CW = (LINE_W > 1) ? $clog2(LINE_W) : 1;

  logic [PIX_W-1:0] lb_near [LINE_W];
  logic [PIX_W-1:0] lb_far  [LINE_W];
  logic [PIX_W-1:0] col0 [KDIM];
  logic [PIX_W-1:0] col1 [KDIM];
  logic [PIX_W-1:0] col2 [KDIM];
  logic [CW-1:0]    col_q, cur_x;
  logic [1:0]       row_q, cur_y;

  always_comb begin
    cur_x = (sol || sof) ? '0 : col_q;
    if (sof)      cur_y = 2'd0;
    else if (sol) cur_y = (row_q == 2'd2) ? 2'd2 : row_q + 2'd1;
    else          cur_y = row_q;
  end

  assign col0[0] = lb_far[cur_x];
  assign col0[1] = lb_near[cur_x];
  assign col0[2] = pix;
  assign border  = (cur_y < 2'd2) || (cur_x < CW'(2));

  for (genvar r = 0; r < KDIM; r++) begin : g_row
    assign win_flat[(KDIM*r+0)*PIX_W +: PIX_W] = col2[r];
    assign win_flat[(KDIM*r+1)*PIX_W +: PIX_W] = col1[r];
    assign win_flat[(KDIM*r+2)*PIX_W +: PIX_W] = col0[r];
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      lb_near[cur_x] <= pix;
      lb_far[cur_x]  <= lb_near[cur_x];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
      for (int r = 0; r < KDIM; r++) begin
        col1[r] <= '0;
        col2[r] <= '0;
      end
    end else if (adv) begin
      col_q <= (cur_x == CW'(LINE_W-1)) ? '0 : cur_x + CW'(1);
      row_q <= cur_y;
      for (int r = 0; r < KDIM; r++) begin
        col1[r] <= col0[r];
        col2[r] <= col1[r];
      end
    end
  end

  // R7: frame start restarts the line count
  a_r7_row_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sof) |=> (row_q == 2'd0));
  // R10: line start restarts the column count
  a_r10_col_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (sol || sof)) |=> (col_q == CW'(1)));
endmodule

// File: rtl/conv3_mac.sv
module conv3_mac
  import conv3_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int SH_W   = 5
) (
  input  logic [NTAP*PIX_W-1:0]   win_flat,
  input  logic [NTAP*COEF_W-1:0]  coef_flat,
  input  logic [SH_W-1:0]         shift,
  output logic [PIX_W-1:0]        res
);
  localparam int ACC_W = PIX_W + COEF_W + 5;
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] prod [NTAP];
  logic signed [ACC_W-1:0] sum, scaled;

  for (genvar k = 0; k < NTAP; k++) begin : g_mul
    logic signed [PIX_W:0]    px;
    logic signed [COEF_W-1:0] cf;
    assign px = $signed({1'b0, win_flat[k*PIX_W +: PIX_W]});
    assign cf = $signed(coef_flat[k*COEF_W +: COEF_W]);
    assign prod[k] = ACC_W'(px) * ACC_W'(cf);
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < NTAP; k++) sum = sum + prod[k];
    scaled = sum >>> shift;
    if (scaled < 0)         res = '0;
    else if (scaled > MAXV) res = MAXV[PIX_W-1:0];
    else                    res = scaled[PIX_W-1:0];
  end
endmodule

// File: rtl/conv3x3_stream.sv
module conv3x3_stream
  import conv3_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int SH_W   = 5,
  parameter int LINE_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cw_en,
  input  logic [IDX_W-1:0]  cw_idx,
  input  logic [COEF_W-1:0] cw_data,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [PIX_W-1:0]  s_data,
  input  logic              s_sof,
  input  logic              s_sol,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [PIX_W-1:0]  m_data,
  output logic              m_sof,
  output logic              m_sol
);
  logic [NTAP*COEF_W-1:0] coef_flat;
  logic [NTAP*PIX_W-1:0]  win_flat;
  logic [SH_W-1:0]        shift;
  logic [PIX_W-1:0]       mac_res, o_data;
  logic                   border, s_fire, adv;
  logic                   o_valid, o_sof, o_sol;

  assign s_ready = en ? (!o_valid || m_ready) : (!o_valid && m_ready);
  assign s_fire  = s_valid && s_ready;
  assign adv     = s_fire && en;

  conv3_coef_regs #(.COEF_W(COEF_W), .SH_W(SH_W), .IDX_W(IDX_W)) u_coef (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(cw_en), .wr_idx(cw_idx),
    .wr_data(cw_data), .coef_flat(coef_flat), .shift(shift));

  conv3_window #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_win (
    .clk(clk), .rst_n(rst_n), .adv(adv), .pix(s_data), .sof(s_sof),
    .sol(s_sol), .win_flat(win_flat), .border(border));

  conv3_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .SH_W(SH_W)) u_mac (
    .win_flat(win_flat), .coef_flat(coef_flat), .shift(shift), .res(mac_res));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= '0;
      o_sof   <= 1'b0;
      o_sol   <= 1'b0;
    end else if (adv) begin
      o_valid <= 1'b1;
      o_data  <= border ? '0 : mac_res;
      o_sof   <= s_sof;
      o_sol   <= s_sol;
    end else if (m_ready) begin
      o_valid <= 1'b0;
    end
  end

  assign m_valid = o_valid || (!en && s_valid);
  assign m_data  = o_valid ? o_data : s_data;
  assign m_sof   = o_valid ? o_sof  : s_sof;
  assign m_sol   = o_valid ? o_sol  : s_sol;

  // R9: a stalled output holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !m_ready) |=> (o_valid && $stable(o_data) && $stable(o_sof) && $stable(o_sol)));
  // R6: every accepted pixel yields an output on the next cycle
  a_r6_one_out: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> m_valid);
  // R5: border positions leave as zero
  a_r5_border_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && border) |=> (m_data == '0));
endmodule

// File: tb/conv3x3_stream_tb.sv
`timescale 1ns/1ps
module conv3x3_stream_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, cw_en = 1'b0;
  logic [3:0] cw_idx = '0;
  logic [7:0] cw_data = '0;
  logic s_valid = 1'b0, s_sof = 1'b0, s_sol = 1'b0, m_ready = 1'b1;
  logic [7:0] s_data = '0;
  logic s_ready, m_valid, m_sof, m_sol;
  logic [7:0] m_data;

  always #2 clk = ~clk;

  conv3x3_stream u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cw_en(cw_en), .cw_idx(cw_idx),
    .cw_data(cw_data), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sof(s_sof), .s_sol(s_sol), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_sof(m_sof), .m_sol(m_sol));

  int checks = 0, failures = 0, bp = 0, shm = 0;
  int cm [9];
  int img [8][32];
  int exp_d [$];
  int exp_m [$];
  string exp_t [$];
  string itag = "R4";
  bit stall_prev = 0;
  int prev_d = 0, prev_m = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int model(int y, int x);
    int s = 0;
    if (y < 2 || x < 2) return 0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        s += cm[3*r+c] * img[y-2+r][x-2+c];
    s = s >>> shm;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  function automatic logic rnd_ready();
    return (($urandom % 100) >= bp);
  endfunction

  task automatic obs();
    int e, em;
    string t;
    if (en) begin
      if (stall_prev)
        chk(m_valid && (int'(m_data) == prev_d) && (int'({m_sof, m_sol}) == prev_m), "R9", m_data, prev_d);
      stall_prev = m_valid && !m_ready;
      prev_d = m_data;
      prev_m = {m_sof, m_sol};
      if (m_valid && m_ready) begin
        if (exp_d.size() == 0) chk(1'b0, "R6", 1, 0);
        else begin
          e = exp_d.pop_front(); em = exp_m.pop_front(); t = exp_t.pop_front();
          chk(int'(m_data) == e, t, m_data, e);
          chk(int'({m_sof, m_sol}) == em, "R6", {m_sof, m_sol}, em);
        end
      end
    end else begin
      stall_prev = 0;
      chk((m_valid == s_valid) && (s_ready == m_ready), "R8", {m_valid, s_ready}, {s_valid, m_ready});
      if (s_valid)
        chk((m_data == s_data) && (m_sof == s_sof) && (m_sol == s_sol), "R8", m_data, s_data);
    end
  endtask

  task automatic send(int v, bit sf, bit sl, string tg, int e);
    bit done = 0;
    while (!done) begin
      if ($urandom % 4 == 0) begin
        s_valid = 0; m_ready = rnd_ready();
        #1 obs();
        @(negedge clk);
      end
      s_valid = 1; s_data = 8'(v); s_sof = sf; s_sol = sl; m_ready = rnd_ready();
      #1 obs();
      done = s_ready;
      if (done && en) begin
        exp_d.push_back(e); exp_m.push_back({sf, sl}); exp_t.push_back(tg);
      end
      @(negedge clk);
    end
    s_valid = 0;
  endtask

  task automatic drain();
    s_valid = 0;
    for (int i = 0; i < 20; i++) begin
      m_ready = 1; #1 obs(); @(negedge clk);
    end
    if (en) chk(exp_d.size() == 0, "R6", exp_d.size(), 0);
  endtask

  task automatic run_frame(int rows, int cols, int pat);
    for (int y = 0; y < rows; y++)
      for (int x = 0; x < cols; x++)
        case (pat)
          0: img[y][x] = int'($urandom % 256);
          1: img[y][x] = 255;
          2: img[y][x] = (x * 15 + y * 7) % 256;
          default: img[y][x] = ((x + y) % 2) ? 200 : 10;
        endcase
    for (int y = 0; y < rows; y++)
      for (int x = 0; x < cols; x++)
        send(img[y][x], (y == 0 && x == 0), (x == 0),
             (y < 2 || x < 2) ? "R5" : itag, model(y, x));
    drain();
  endtask

  task automatic wcoef(int idx, int val);
    cw_en = 1; cw_idx = 4'(idx); cw_data = 8'(val);
    #1 obs();
    if (!en) begin
      if (idx < 9) cm[idx] = int'($signed(8'(val)));
      else shm = val & 31;
    end
    @(negedge clk);
    cw_en = 0;
  endtask

  task automatic load_kernel(int k0, int k1, int k2, int k3, int k4,
                             int k5, int k6, int k7, int k8, int sh);
    wcoef(0, k0); wcoef(1, k1); wcoef(2, k2); wcoef(3, k3); wcoef(4, k4);
    wcoef(5, k5); wcoef(6, k6); wcoef(7, k7); wcoef(8, k8); wcoef(9, sh);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 9; i++) cm[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    en = 1; m_ready = 1;
    #1;
    chk(!m_valid, "R1", m_valid, 0);
    chk(s_ready, "R1", s_ready, 1);
    @(negedge clk);
    // R1: zero kernel after reset gives all-zero output
    bp = 20; itag = "R1";
    run_frame(4, W, 0);

    // R2: load a smoothing kernel while disabled
    en = 0; @(negedge clk);
    load_kernel(1, 2, 1, 2, 4, 2, 1, 2, 1, 4);
    en = 1; @(negedge clk);
    bp = 30; itag = "R2";
    run_frame(5, W, 0);

    // R4: asymmetric kernel reveals tap placement
    en = 0; @(negedge clk);
    load_kernel(3, -1, 0, 0, 2, 0, -2, 0, 1, 1);
    en = 1; @(negedge clk);
    itag = "R4";
    run_frame(5, W, 0);

    // R4: upper clamp
    en = 0; @(negedge clk);
    load_kernel(1, 1, 1, 1, 1, 1, 1, 1, 1, 0);
    en = 1; @(negedge clk);
    run_frame(4, W, 1);

    // R4: lower clamp
    en = 0; @(negedge clk);
    load_kernel(1, 0, 1, 0, -128, 0, 1, 0, 1, 2);
    en = 1; @(negedge clk);
    run_frame(4, W, 0);

    // R3: writes while enabled are ignored
    en = 0; @(negedge clk);
    load_kernel(0, 1, 0, 1, -4, 1, 0, 1, 0, 0);
    en = 1; @(negedge clk);
    wcoef(4, 100); wcoef(0, -50); wcoef(9, 7);
    itag = "R3";
    run_frame(5, W, 2);

    // R7: frames back to back with very different content, plus a one-line frame
    en = 0; @(negedge clk);
    load_kernel(1, 1, 1, 1, 1, 1, 1, 1, 1, 3);
    en = 1; @(negedge clk);
    itag = "R7";
    run_frame(4, W, 1);
    run_frame(1, W, 1);
    run_frame(4, W, 3);

    // R10: short lines
    itag = "R10";
    run_frame(5, 12, 0);

    // R9: heavy back-pressure
    bp = 70; itag = "R9";
    run_frame(4, W, 0);

    // R8: pass-through under stalls
    bp = 30;
    en = 0; @(negedge clk);
    run_frame(4, W, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule